// File: doc/BRIEF.md
# Synchronous Memory-Card Link Controller

This block is the card-side engine of a two-wire synchronous memory-card link. The interface device supplies a card clock and a card reset and shares one open-drain data line with the card. The block oversamples these three lines with the chip clock. It then performs the answer-to-reset, detects start and stop conditions, and collects a three-byte command. It serialises read data from the main array or the protection bits. For the two data-changing commands it holds the line low while a separate processing sequencer does the work.

The block owns no storage. Main memory and protection bits are read through plain read ports: the read is combinational and the data must be valid in the same cycle as the address. Update and protection-write requests leave on a valid/ready stream. The payload stays unchanged while `req_valid` is high and `req_ready` is low, and the request is transferred in the cycle where both are high. The one exception is a break, which withdraws a pending request without a transfer. The sequencer ends the job with a one-cycle `seq_done` or `seq_error` pulse.

Top module: `sync_card_link`

## Requirements
- R1: The card only ever pulls the data line low (`card_io_drive_low`=1) or releases it; after chip reset the line is released and no request is pending.
- R2: If card reset falls while the card clock is high, the line carries bit 0 of byte 0. Each of the next 31 clock pulses puts the following bit of bytes 0..3 (LSB first) on the line at its falling edge. The pulse after those releases the line.
- R3: A start is a falling data line while the card clock is high, and a stop is a rising data line while the card clock is high. Both are ignored during answer-to-reset, outgoing data and processing.
- R4: A command is 24 bits sampled on rising card-clock edges, LSB first, in the order control, address, data. The pulse that carries the stop is a 25th rising edge, and any other count is a failure.
- R5: Control 0x30 outputs main-memory bits from byte n (the address byte) to the last byte, one bit per pulse, each at a falling edge after the stop. The pulse after the last bit releases the line.
- R6: Control 0x34 outputs the 32 protection bits (bit 0 first, address byte ignored) over 32 pulses, and the 33rd pulse releases the line.
- R7: Controls 0x38 (update, `req_protect`=0) and 0x3C (protection write, `req_protect`=1) raise `req_valid` with the address and data bytes. The payload is held stable until `req_ready`.
- R8: In processing, the first falling card-clock edge after the stop pulls the line low. The line stays low until `seq_done` or `seq_error` has been seen, and is released at the next falling edge after that.
- R9: Card reset high aborts any mode at once: the line is released, a pending request is withdrawn, and the block waits for a new reset pulse or start.
- R10: An unknown control byte or a wrong bit count leaves the line released, issues no request and returns to waiting for a start.
- R11: Update and protection-write commands are failures (no request, line released) until an answer-to-reset or a read command has been carried out since chip reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the card lines |
| rst_n | input | 1 | Active-low chip reset |
| card_clk | input | 1 | Card clock from the interface device |
| card_rst | input | 1 | Card reset from the interface device |
| card_io_in | input | 1 | Resolved level of the shared data line |
| card_io_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_raddr | output | 8 | Main-memory read address |
| mem_rdata | input | 8 | Main-memory read data, valid in the same cycle |
| prot_rdata | input | 32 | Current protection bits, bit i for byte i |
| req_valid | output | 1 | Processing request valid |
| req_ready | input | 1 | Sequencer accepts the request |
| req_protect | output | 1 | 1 protection write, 0 main-memory update |
| req_addr | output | 8 | Target byte address |
| req_data | output | 8 | Command data byte |
| seq_done | input | 1 | One-cycle pulse: processing finished |
| seq_error | input | 1 | One-cycle pulse: processing refused or failed |

## Verification
A break and the end of processing can land on the same chip-clock edge. The bench holds a job in processing and then raises card reset and pulses `seq_done` on the same cycle. It expects the break to win: the line is released at once and stays released on the following pulses. A later read must then run normally, which shows that the late completion left no state behind. A start/stop pair injected in the middle of an outgoing protection read is checked the same way: the bit stream must continue unbroken.

// File: rtl/sync_card_pkg.sv
`timescale 1ns/1ps
package sync_card_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_ATR,
    MODE_CMD,
    MODE_OUT,
    MODE_PROC
  } link_mode_e;

  localparam logic [7:0] CTL_READ_MAIN  = 8'h30;
  localparam logic [7:0] CTL_UPDATE     = 8'h38;
  localparam logic [7:0] CTL_READ_PROT  = 8'h34;
  localparam logic [7:0] CTL_WRITE_PROT = 8'h3C;
endpackage

// File: rtl/card_line_sync.sv
`timescale 1ns/1ps
module card_line_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{INIT[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end
endmodule

// File: rtl/cmd_shift_rx.sv
`timescale 1ns/1ps
module cmd_shift_rx #(
  parameter int NBITS = 24,
  localparam int CW = $clog2(NBITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             din,
  output logic [NBITS-1:0] bits,
  output logic [CW-1:0]    count
);
  localparam logic [CW-1:0] LIMIT = CW'(NBITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits  <= '0;
      count <= '0;
    end else if (clear) begin
      bits  <= '0;
      count <= '0;
    end else if (sample) begin
      if (count < LIMIT) bits[count] <= din;
      if (count != '1) count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/serial_bit_source.sv
`timescale 1ns/1ps
module serial_bit_source #(
  parameter int MEM_BYTES = 256,
  parameter int PROT_BITS = 32,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int PW  = AW + 3,
  localparam int PIW = $clog2(PROT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PW-1:0]        load_ptr,
  input  logic [PW:0]          load_limit,
  input  logic                 load_prot,
  input  logic                 advance,
  input  logic [7:0]           mem_rdata,
  input  logic [PROT_BITS-1:0] prot_rdata,
  output logic [AW-1:0]        mem_raddr,
  output logic                 bit_val,
  output logic                 at_last
);
  logic [PW-1:0] ptr;
  logic [PW:0]   limit;
  logic          use_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      limit    <= '0;
      use_prot <= 1'b0;
    end else if (load) begin
      ptr      <= load_ptr;
      limit    <= load_limit;
      use_prot <= load_prot;
    end else if (advance) begin
      ptr <= ptr + PW'(1);
    end
  end

  assign mem_raddr = ptr[PW-1:3];
  assign bit_val   = use_prot ? prot_rdata[ptr[PIW-1:0]] : mem_rdata[ptr[2:0]];
  assign at_last   = ({1'b0, ptr} + (PW+1)'(1)) == limit;
endmodule

// File: rtl/sync_card_link.sv
`timescale 1ns/1ps
module sync_card_link
  import sync_card_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int PROT_BITS = 32,
  parameter int ATR_BYTES = 4,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = AW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 card_clk,
  input  logic                 card_rst,
  input  logic                 card_io_in,
  output logic                 card_io_drive_low,
  output logic [AW-1:0]        mem_raddr,
  input  logic [7:0]           mem_rdata,
  input  logic [PROT_BITS-1:0] prot_rdata,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic                 req_protect,
  output logic [7:0]           req_addr,
  output logic [7:0]           req_data,
  input  logic                 seq_done,
  input  logic                 seq_error
);
  localparam int CMD_BITS = 24;
  localparam int CW = $clog2(CMD_BITS + 2);
  localparam logic [PW:0] ATR_LIM  = (PW+1)'(ATR_BYTES * 8);
  localparam logic [PW:0] MAIN_LIM = (PW+1)'(MEM_BYTES * 8);
  localparam logic [PW:0] PROT_LIM = (PW+1)'(PROT_BITS);

  // Oversampled card lines and their previous samples
  logic [2:0] line_q;
  logic s_clk, s_rst, s_io, p_clk, p_rst, p_io;

  card_line_sync #(.W(3), .INIT(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({card_io_in, card_rst, card_clk}), .q(line_q)
  );
  assign s_clk = line_q[0];
  assign s_rst = line_q[1];
  assign s_io  = line_q[2];

  logic clk_rise, clk_fall, rst_fall, start_cond, stop_cond;
  assign clk_rise   = s_clk & ~p_clk;
  assign clk_fall   = ~s_clk & p_clk;
  assign rst_fall   = ~s_rst & p_rst;
  assign start_cond = s_clk & p_clk & p_io & ~s_io;
  assign stop_cond  = s_clk & p_clk & ~p_io & s_io;

  link_mode_e mode;
  logic armed, started, finished, refresh, unlocked, io_low;

  // Command reception
  logic [CMD_BITS-1:0] rx_bits;
  logic [CW-1:0]       rx_count;
  logic rx_clear, rx_sample;
  assign rx_clear  = ~s_rst & start_cond & (mode == MODE_IDLE || mode == MODE_CMD);
  assign rx_sample = ~s_rst & clk_rise & (mode == MODE_CMD);

  cmd_shift_rx #(.NBITS(CMD_BITS)) i_rx (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .sample(rx_sample),
    .din(s_io), .bits(rx_bits), .count(rx_count)
  );

  logic [7:0] ctl, adr, dat;
  logic len_ok, stop_eval, go_read_main, go_read_prot, go_write, atr_go;
  assign ctl = rx_bits[7:0];
  assign adr = rx_bits[15:8];
  assign dat = rx_bits[23:16];
  assign len_ok       = (rx_count == CW'(CMD_BITS + 1));
  assign stop_eval    = ~s_rst & stop_cond & (mode == MODE_CMD) & len_ok;
  assign go_read_main = stop_eval & (ctl == CTL_READ_MAIN);
  assign go_read_prot = stop_eval & (ctl == CTL_READ_PROT);
  assign go_write     = stop_eval & unlocked &
                        (ctl == CTL_UPDATE || ctl == CTL_WRITE_PROT);
  assign atr_go       = ~s_rst & rst_fall & s_clk;

  // Serial bit source shared by answer-to-reset and both reads
  logic          src_load, src_adv, bit_val, at_last;
  logic [PW-1:0] src_ptr;
  logic [PW:0]   src_limit;
  logic          shift_fall;

  assign shift_fall = ~s_rst & clk_fall & armed &
                      (mode == MODE_ATR || mode == MODE_OUT);
  assign src_adv    = shift_fall & started & ~at_last;
  assign src_load   = atr_go | go_read_main | go_read_prot;
  assign src_ptr    = go_read_main ? PW'({adr, 3'b000}) : '0;
  assign src_limit  = atr_go ? ATR_LIM : (go_read_main ? MAIN_LIM : PROT_LIM);

  serial_bit_source #(.MEM_BYTES(MEM_BYTES), .PROT_BITS(PROT_BITS)) i_src (
    .clk(clk), .rst_n(rst_n),
    .load(src_load), .load_ptr(src_ptr), .load_limit(src_limit),
    .load_prot(go_read_prot), .advance(src_adv),
    .mem_rdata(mem_rdata), .prot_rdata(prot_rdata),
    .mem_raddr(mem_raddr), .bit_val(bit_val), .at_last(at_last)
  );

  // Mode sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_clk <= 1'b0; p_rst <= 1'b0; p_io <= 1'b1;
      mode <= MODE_IDLE;
      armed <= 1'b0; started <= 1'b0; finished <= 1'b0;
      refresh <= 1'b0; unlocked <= 1'b0; io_low <= 1'b0;
      req_valid <= 1'b0; req_protect <= 1'b0;
      req_addr <= '0; req_data <= '0;
    end else begin
      p_clk <= s_clk; p_rst <= s_rst; p_io <= s_io;
      if (s_rst) begin
        mode <= MODE_IDLE;
        io_low <= 1'b0;
        refresh <= 1'b0;
        req_valid <= 1'b0;
        armed <= 1'b0;
        finished <= 1'b0;
      end else begin
        refresh <= 1'b0;
        if (refresh) io_low <= ~bit_val;
        if (clk_rise) armed <= 1'b1;
        if (req_valid && req_ready) req_valid <= 1'b0;
        if (mode == MODE_PROC && (seq_done || seq_error)) finished <= 1'b1;
        if (atr_go) begin
          mode <= MODE_ATR;
          started <= 1'b1;
          refresh <= 1'b1;
          armed <= 1'b0;
          unlocked <= 1'b1;
        end else begin
          case (mode)
            MODE_IDLE: if (start_cond) mode <= MODE_CMD;
            MODE_CMD: if (stop_cond) begin
              if (go_read_main || go_read_prot) begin
                mode <= MODE_OUT;
                started <= 1'b0;
                armed <= 1'b0;
                unlocked <= 1'b1;
              end else if (go_write) begin
                mode <= MODE_PROC;
                armed <= 1'b0;
                finished <= 1'b0;
                req_valid <= 1'b1;
                req_protect <= (ctl == CTL_WRITE_PROT);
                req_addr <= adr;
                req_data <= dat;
              end else begin
                mode <= MODE_IDLE;
              end
            end
            MODE_ATR, MODE_OUT: if (clk_fall && armed) begin
              armed <= 1'b0;
              if (!started) begin
                started <= 1'b1;
                refresh <= 1'b1;
              end else if (at_last) begin
                io_low <= 1'b0;
                mode <= MODE_IDLE;
              end else begin
                refresh <= 1'b1;
              end
            end
            MODE_PROC: if (clk_fall && armed) begin
              armed <= 1'b0;
              if (finished) begin
                io_low <= 1'b0;
                mode <= MODE_IDLE;
              end else begin
                io_low <= 1'b1;
              end
            end
            default: mode <= MODE_IDLE;
          endcase
        end
      end
    end
  end

  assign card_io_drive_low = io_low;
endmodule

// File: rtl/sync_card_link_props.sv
`timescale 1ns/1ps
module sync_card_link_props
  import sync_card_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       s_rst,
  input link_mode_e mode,
  input logic       io_low,
  input logic       unlocked,
  input logic       stop_cond,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_protect,
  input logic [7:0] req_addr,
  input logic [7:0] req_data
);
  assert_break_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_rst |=> !io_low);

  assert_quiet_listen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE || mode == MODE_CMD) |-> !io_low);

  assert_drive_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_low) |-> (mode == MODE_ATR || mode == MODE_OUT || mode == MODE_PROC));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !s_rst) |=>
      (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_protect)));

  assert_req_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> unlocked);

  assert_req_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(stop_cond));
endmodule

bind sync_card_link sync_card_link_props i_props (
  .clk(clk), .rst_n(rst_n), .s_rst(s_rst), .mode(mode), .io_low(io_low),
  .unlocked(unlocked), .stop_cond(stop_cond), .req_valid(req_valid),
  .req_ready(req_ready), .req_protect(req_protect),
  .req_addr(req_addr), .req_data(req_data)
);

// File: tb/test_sync_card_link.sv
`timescale 1ns/1ps
module test_sync_card_link;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_clk_d = 1'b0, card_rst_d = 1'b0, ifd_low = 1'b0;
  logic io_line, drive_low;
  logic [7:0] mem_raddr, mem_rdata;
  logic [31:0] bprot;
  logic req_valid, req_ready, req_protect;
  logic [7:0] req_addr, req_data;
  logic seq_done = 1'b0, seq_error = 1'b0;
  logic [7:0] bmem [256];

  int n_checks = 0, n_errors = 0;
  bit all_done = 1'b0;
  bit done_flag;
  int req_seen;
  logic [7:0] cap_addr, cap_data;
  logic cap_prot;

  always #10 clk = ~clk;

  assign mem_rdata = bmem[mem_raddr];
  assign io_line   = ~(drive_low | ifd_low);

  sync_card_link i_sync_card_link (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk_d), .card_rst(card_rst_d),
    .card_io_in(io_line), .card_io_drive_low(drive_low),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .prot_rdata(bprot),
    .req_valid(req_valid), .req_ready(req_ready), .req_protect(req_protect),
    .req_addr(req_addr), .req_data(req_data),
    .seq_done(seq_done), .seq_error(seq_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    card_clk_d = 1'b1; wait_sys(HALF);
    card_clk_d = 1'b0; wait_sys(HALF);
  endtask

  task automatic send_frame(input logic [7:0] c, input logic [7:0] a,
                            input logic [7:0] d, input int nbits);
    logic [23:0] w;
    w = {d, a, c};
    ifd_low = 1'b0; card_clk_d = 1'b1; wait_sys(HALF);
    ifd_low = 1'b1; wait_sys(HALF);
    card_clk_d = 1'b0; wait_sys(HALF);
    for (int i = 0; i < nbits; i++) begin
      ifd_low = ~w[i % 24]; wait_sys(HALF);
      card_clk_d = 1'b1; wait_sys(HALF);
      card_clk_d = 1'b0;
    end
    ifd_low = 1'b1; wait_sys(HALF);
    card_clk_d = 1'b1; wait_sys(HALF);
    ifd_low = 1'b0; wait_sys(HALF);
    card_clk_d = 1'b0; wait_sys(HALF);
  endtask

  // Outgoing stream: one expected bit per pulse, then release
  task automatic expect_main(input string req, input int first);
    for (int k = first * 8; k < 256 * 8; k++) begin
      pulse();
      chk(req, io_line, bmem[k / 8][k % 8]);
    end
    pulse();
    chk({req, " release"}, io_line, 1);
  endtask

  task automatic seq_serve(input int hold, input int npulses, input bit fail);
    while (!req_valid) @(negedge clk);
    wait_sys(hold);
    cap_addr = req_addr; cap_data = req_data; cap_prot = req_protect;
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    req_seen++;
    repeat (npulses) @(posedge card_clk_d);
    wait_sys(2);
    if (fail) seq_error = 1'b1; else seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0; seq_error = 1'b0;
    if (!fail) bmem[cap_addr] = cap_data;
    done_flag = 1'b1;
  endtask

  task automatic proc_watch(input string req);
    bit rel;
    bit exp_rel;
    rel = 1'b0;
    for (int i = 1; i <= 20 && !rel; i++) begin
      card_clk_d = 1'b1; wait_sys(HALF);
      exp_rel = done_flag;
      card_clk_d = 1'b0; wait_sys(HALF);
      chk(req, io_line, exp_rel);
      if (exp_rel) rel = 1'b1;
    end
    chk({req, " released"}, rel, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 11);
    bprot = 32'hA5C3_0F1E;
    req_ready = 1'b0;
    req_seen = 0;
    done_flag = 1'b0;
    wait_sys(5);
    rst_n = 1'b1;
    wait_sys(5);

    // R1: reset state
    chk("R1 line released after reset", io_line, 1);
    chk("R1 no request after reset", req_valid, 0);

    // R11: update before any answer-to-reset or read
    send_frame(8'h38, 8'd5, 8'h00, 24);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R11 locked update keeps line high", io_line, 1);
    end
    chk("R11 locked update issues no request", req_valid, 0);

    // R2: answer-to-reset
    card_rst_d = 1'b1; wait_sys(HALF);
    card_clk_d = 1'b1; wait_sys(HALF);
    card_rst_d = 1'b0; wait_sys(HALF);
    chk("R2 first ATR bit at reset fall", io_line, bmem[0][0]);
    card_clk_d = 1'b0; wait_sys(HALF);
    chk("R2 first ATR bit holds over first fall", io_line, bmem[0][0]);
    for (int k = 1; k < 32; k++) begin
      pulse();
      chk("R2 ATR bit", io_line, bmem[k / 8][k % 8]);
    end
    pulse();
    chk("R2 33rd pulse releases", io_line, 1);

    // R5: reads near the end of the array
    send_frame(8'h30, 8'd250, 8'h77, 24);
    expect_main("R5 read main from 250", 250);
    send_frame(8'h30, 8'd255, 8'h00, 24);
    expect_main("R5 read main from 255", 255);

    // R6 with an injected start/stop pair in mid-stream (R3)
    send_frame(8'h34, 8'h99, 8'h00, 24);
    for (int k = 0; k < 32; k++) begin
      card_clk_d = 1'b1; wait_sys(3);
      if (k == 5) begin
        ifd_low = 1'b1; wait_sys(2); ifd_low = 1'b0;
      end
      wait_sys(HALF);
      card_clk_d = 1'b0; wait_sys(HALF);
      chk("R6 R3 protection bit", io_line, bprot[k]);
    end
    pulse();
    chk("R6 33rd pulse releases", io_line, 1);

    // R10: unknown control
    send_frame(8'h31, 8'd0, 8'h00, 24);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R10 unknown control leaves line high", io_line, 1);
    end
    // R4: short command
    send_frame(8'h38, 8'd3, 8'h12, 23);
    pulse();
    chk("R4 short frame leaves line high", io_line, 1);
    chk("R4 short frame issues no request", req_seen, 0);

    // R7, R8: update with back-pressure
    done_flag = 1'b0;
    fork
      seq_serve(30, 3, 1'b0);
      begin
        send_frame(8'h38, 8'd7, 8'h5A, 24);
        chk("R7 valid held under back-pressure", req_valid, 1);
        chk("R7 update kind", req_protect, 0);
        proc_watch("R8 update processing");
      end
    join
    chk("R7 captured address", cap_addr, 8'd7);
    chk("R7 captured data", cap_data, 8'h5A);
    chk("R7 one request transferred", req_seen, 1);

    // R8 with a sequencer error on a protection write
    done_flag = 1'b0;
    fork
      seq_serve(2, 2, 1'b1);
      begin
        send_frame(8'h3C, 8'd40, 8'h11, 24);
        proc_watch("R8 protect with error");
      end
    join
    chk("R7 protect kind", cap_prot, 1);
    chk("R7 protect address", cap_addr, 8'd40);

    // R9: break during outgoing data
    send_frame(8'h30, 8'd200, 8'h00, 24);
    for (int k = 0; k < 5; k++) pulse();
    card_rst_d = 1'b1; wait_sys(HALF);
    chk("R9 break releases line", io_line, 1);
    card_rst_d = 1'b0; wait_sys(HALF);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R9 line stays released after break", io_line, 1);
    end
    send_frame(8'h30, 8'd255, 8'h00, 24);
    expect_main("R9 read after break", 255);

    // R9 break on the same cycle as seq_done
    send_frame(8'h38, 8'd9, 8'hC3, 24);
    while (!req_valid) @(negedge clk);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    pulse();
    chk("R8 processing pulls line low", io_line, 0);
    card_rst_d = 1'b1; seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
    wait_sys(HALF);
    chk("R9 break with done releases line", io_line, 1);
    chk("R9 break leaves no request", req_valid, 0);
    card_rst_d = 1'b0; wait_sys(HALF);
    pulse();
    chk("R9 line stays released", io_line, 1);
    send_frame(8'h34, 8'h00, 8'h00, 24);
    for (int k = 0; k < 32; k++) begin
      pulse();
      chk("R9 R6 protection read after break", io_line, bprot[k]);
    end
    pulse();
    chk("R6 release after recovery read", io_line, 1);

    all_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!all_done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule